// File: doc/BRIEF.md
# Deep Power-Down and Hold Sequencer

This block supervises the power state of a serial memory's command front end and the pause (hold) condition on its serial port. It runs on the system clock. All of its inputs are assumed to be already synchronised to that clock: chip select, the serial clock, the active-low hold line, the opcode decoded in the current frame, the count of serial bits seen in the frame, an internal write-busy flag and a flag that marks quad-width data phases. The power state moves through standby, active, entering deep power-down, deep power-down and releasing. The entry and release delays are counted in system-clock cycles and set by parameters.

The serial engine uses three outputs. `cmd_gate` allows it to execute commands in the current frame. `hold_out` freezes the engine in place and tri-states its output driver. `pwr_ready` is high when the device can accept a new frame. `if_reset` is a one-cycle pulse. It asks the engine to drop its frame state because chip select was released while the port was held. `pwr_state` shows the power state for the engine and for debug.

Top module: `pd_hold_seq`

## Requirements
- R1: After reset `pwr_state` is standby (code 0), `pwr_ready` is 1, and `cmd_gate`, `hold_out` and `if_reset` are 0. The block never leaves reset in deep power-down.
- R2: A chip-select rise with opcode B9h, a bit count of exactly 8, the write-busy flag low and no hold moves the state to entering (code 2) on that clock edge and drops `pwr_ready`. The state becomes deep power-down (code 3) ENTER_CYC+1 cycles later.
- R3: A chip-select rise with any other opcode, or with B9h and a bit count other than 8, returns the state from active to standby with no power change.
- R4: In deep power-down, frames never raise `cmd_gate` or `pwr_ready`. Every opcode is ignored except ABh with a bit count of exactly 8, which moves the state to releasing (code 4).
- R5: ABh is rejected, and the state stays in deep power-down, when the bit count at the chip-select rise is not exactly 8.
- R6: While write-busy is high, neither B9h nor ABh changes the power state.
- R7: Releasing lasts EXIT_CYC+1 cycles and then returns to standby. A frame whose chip-select fall came before standby was reached is never gated. Only the next chip-select fall opens a frame.
- R8: Hold starts when the hold line falls while the serial clock is low, chip select is low and no quad data phase is active. A fall while the serial clock is high, or during a quad data phase, has no effect.
- R9: Hold ends when the hold line is high while the serial clock is low. While held, `cmd_gate` is 0, and serial clock toggles do not change the hold state.
- R10: A chip-select rise during hold gives a one-cycle `if_reset` pulse, makes no power-state change (even with B9h and 8 bits), and leaves hold set. A frame whose chip-select fall comes while hold is still set stays ungated after the hold is released.
- R11: `cmd_gate` is 1 exactly when the state is active (code 1), chip select is low and hold is clear. Active is entered only on a chip-select fall from standby without hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock level |
| hold_n | input | 1 | Hold line, active low |
| opcode | input | 8 | Opcode decoded in the current frame |
| bit_cnt | input | CNT_W | Serial bits received in the current frame |
| wr_busy | input | 1 | Internal array or status write in progress |
| quad_phase | input | 1 | Quad data phase active (hold line used as data) |
| cmd_gate | output | 1 | Command execution allowed in this frame |
| hold_out | output | 1 | Freeze serial engine, tri-state output |
| pwr_ready | output | 1 | Standby or active |
| if_reset | output | 1 | One-cycle interface reset request |
| pwr_state | output | 3 | Power state code |

## Verification
A corrupted power state shows at once on `pwr_state` and `pwr_ready`, on the clock edge after the chip-select rise that should have caused the change. A wrong delay count shifts the deep or standby code by whole cycles, and a bench that samples every cycle of the delay window catches that. A stale hold flag, or one that was missed, shows on `hold_out` and `cmd_gate` on the edge after the hold line moves. A lost interface reset shows as a missing `if_reset` pulse in the cycle after the chip-select rise.

// File: rtl/pd_hold_pkg.sv
package pd_hold_pkg;
  typedef enum logic [2:0] {
    PS_STBY = 3'd0,
    PS_ACT  = 3'd1,
    PS_SINK = 3'd2,
    PS_DEEP = 3'd3,
    PS_WAKE = 3'd4
  } pstate_e;

  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_RISE  = 8'hAB;
endpackage

// File: rtl/pd_dly_timer.sv
module pd_dly_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7
  tmr_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/pd_hold_track.sv
module pd_hold_track (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic hold_n,
  input  logic quad_phase,
  output logic hold_q,
  output logic hold_nx
);
  logic hold_n_q;

  always_comb begin
    hold_nx = hold_q;
    if (hold_q) begin
      if (hold_n && !sclk) hold_nx = 1'b0;
    end else if (!cs_n && !quad_phase && hold_n_q && !hold_n && !sclk) begin
      hold_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= 1'b0;
      hold_n_q <= 1'b1;
    end else begin
      hold_q   <= hold_nx;
      hold_n_q <= hold_n;
    end
  end

  // R8
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> (!$past(sclk) && !$past(cs_n) && !$past(quad_phase) && !$past(hold_n)));

  // R9
  hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> ($past(hold_n) && !$past(sclk)));
endmodule

// File: rtl/pd_pwr_fsm.sv
module pd_pwr_fsm
  import pd_hold_pkg::*;
#(
  parameter int ENTER_CYC = 375,
  parameter int EXIT_CYC  = 375,
  parameter int CNT_W     = 6,
  parameter int OP_BITS   = 8,
  parameter int TW        = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_rise,
  input  logic             cs_fall,
  input  logic             hold_q,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             wr_busy,
  input  logic             tmr_expired,
  output pstate_e          state_q,
  output pstate_e          state_nx,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val
);
  logic frame_ok;

  assign frame_ok = cs_rise && (bit_cnt == CNT_W'(OP_BITS)) && !wr_busy && !hold_q;

  always_comb begin
    state_nx = state_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(ENTER_CYC);
    unique case (state_q)
      PS_STBY: if (cs_fall && !hold_q) state_nx = PS_ACT;
      PS_ACT: begin
        if (frame_ok && opcode == OPC_SLEEP) begin
          state_nx = PS_SINK;
          tmr_load = 1'b1;
        end else if (cs_rise) begin
          state_nx = PS_STBY;
        end
      end
      PS_SINK: if (tmr_expired) state_nx = PS_DEEP;
      PS_DEEP: begin
        if (frame_ok && opcode == OPC_RISE) begin
          state_nx = PS_WAKE;
          tmr_load = 1'b1;
          tmr_val  = TW'(EXIT_CYC);
        end
      end
      PS_WAKE: if (tmr_expired) state_nx = PS_STBY;
      default: state_nx = PS_STBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PS_STBY;
    else     state_q <= state_nx;
  end

  // R2
  sink_path_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SINK) |=> (state_q == PS_SINK || state_q == PS_DEEP));

  // R4
  deep_path_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DEEP) |=> (state_q == PS_DEEP || state_q == PS_WAKE));

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && state_q == PS_ACT) |=> (state_q != PS_SINK));

  // R7
  wake_path_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_WAKE) |=> (state_q == PS_WAKE || state_q == PS_STBY));
endmodule

// File: rtl/pd_hold_seq.sv
module pd_hold_seq
  import pd_hold_pkg::*;
#(
  parameter int ENTER_CYC = 375,
  parameter int EXIT_CYC  = 375,
  parameter int CNT_W     = 6,
  parameter int OP_BITS   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             hold_n,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             wr_busy,
  input  logic             quad_phase,
  output logic             cmd_gate,
  output logic             hold_out,
  output logic             pwr_ready,
  output logic             if_reset,
  output logic [2:0]       pwr_state
);
  localparam int TMAX = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic          cs_q, cs_rise, cs_fall;
  logic          hold_q, hold_nx;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  pstate_e       st_q, st_nx;

  assign cs_rise = !cs_q && cs_n;
  assign cs_fall = cs_q && !cs_n;

  pd_hold_track u_hold (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
    .quad_phase(quad_phase), .hold_q(hold_q), .hold_nx(hold_nx)
  );

  pd_dly_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  pd_pwr_fsm #(
    .ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .CNT_W(CNT_W),
    .OP_BITS(OP_BITS), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_fall(cs_fall), .hold_q(hold_q),
    .opcode(opcode), .bit_cnt(bit_cnt), .wr_busy(wr_busy), .tmr_expired(tmr_exp),
    .state_q(st_q), .state_nx(st_nx), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b1;
      cmd_gate  <= 1'b0;
      pwr_ready <= 1'b1;
      if_reset  <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      cmd_gate  <= (st_nx == PS_ACT) && !cs_n && !hold_nx;
      pwr_ready <= (st_nx == PS_STBY) || (st_nx == PS_ACT);
      if_reset  <= cs_rise && hold_q;
    end
  end

  assign hold_out  = hold_q;
  assign pwr_state = st_q;

  // R11
  gate_qual_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_gate |-> (pwr_ready && !hold_out && pwr_state == 3'd1));

  // R10
  ifrst_src_chk: assert property (@(posedge clk) disable iff (rst)
    if_reset |-> ($past(cs_n) && $past(hold_out)));

  // R10
  ifrst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    if_reset |=> !if_reset);
endmodule

// File: tb/pd_hold_seq_bench.sv
module pd_hold_seq_bench;
  localparam int ENTER_CYC = 6;
  localparam int EXIT_CYC  = 5;
  localparam int CNT_W     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, wr_busy = 1'b0, quad_phase = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [CNT_W-1:0] bit_cnt = '0;
  logic cmd_gate, hold_out, pwr_ready, if_reset;
  logic [2:0] pwr_state;

  always #4 clk = ~clk;

  pd_hold_seq #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .CNT_W(CNT_W)) u_pd_hold_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n), .opcode(opcode),
    .bit_cnt(bit_cnt), .wr_busy(wr_busy), .quad_phase(quad_phase), .cmd_gate(cmd_gate),
    .hold_out(hold_out), .pwr_ready(pwr_ready), .if_reset(if_reset), .pwr_state(pwr_state)
  );

  typedef struct {
    logic [2:0] st;
    logic rdy, gate, hld, irst;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // driver side: expectation for the outputs after the coming rising edge
  task automatic expect_step(input logic [2:0] st, input logic rdy, input logic gate,
                             input logic hld, input logic irst, input string tag);
    exp_t e;
    e.st = st; e.rdy = rdy; e.gate = gate; e.hld = hld; e.irst = irst; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor side
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (pwr_state !== e.st || pwr_ready !== e.rdy || cmd_gate !== e.gate ||
            hold_out !== e.hld || if_reset !== e.irst) begin
          n_fail++;
          $display("FAIL %s: got st=%0d rdy=%0b gate=%0b hold=%0b irst=%0b exp st=%0d rdy=%0b gate=%0b hold=%0b irst=%0b",
                   e.tag, pwr_state, pwr_ready, cmd_gate, hold_out, if_reset,
                   e.st, e.rdy, e.gate, e.hld, e.irst);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic close_frame(input logic [7:0] op, input int bits);
    opcode = op; bit_cnt = CNT_W'(bits); cs_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_step(3'd0, 1, 0, 0, 0, "R1 reset state");

    cs_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R11 frame opens gate");
    close_frame(8'hB9, 9);
    expect_step(3'd0, 1, 0, 0, 0, "R3 sleep opcode with extra bits");
    cs_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R11 second frame");
    close_frame(8'h06, 8);
    expect_step(3'd0, 1, 0, 0, 0, "R3 other opcode");

    cs_n = 1'b0; wr_busy = 1'b1;
    expect_step(3'd1, 1, 1, 0, 0, "R11 frame under busy");
    close_frame(8'hB9, 8);
    expect_step(3'd0, 1, 0, 0, 0, "R6 sleep blocked by busy");
    wr_busy = 1'b0;

    cs_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R11 frame before sleep");
    close_frame(8'hB9, 8);
    expect_step(3'd2, 0, 0, 0, 0, "R2 entering");
    for (int k = 0; k < ENTER_CYC; k++) expect_step(3'd2, 0, 0, 0, 0, "R2 entry delay");
    expect_step(3'd3, 0, 0, 0, 0, "R2 deep reached");

    cs_n = 1'b0;
    expect_step(3'd3, 0, 0, 0, 0, "R4 frame in deep not gated");
    close_frame(8'h05, 8);
    expect_step(3'd3, 0, 0, 0, 0, "R4 other opcode ignored");
    cs_n = 1'b0;
    expect_step(3'd3, 0, 0, 0, 0, "R4 frame in deep");
    close_frame(8'hAB, 12);
    expect_step(3'd3, 0, 0, 0, 0, "R5 release with extra clocks");
    cs_n = 1'b0; wr_busy = 1'b1;
    expect_step(3'd3, 0, 0, 0, 0, "R4 frame in deep busy");
    close_frame(8'hAB, 8);
    expect_step(3'd3, 0, 0, 0, 0, "R6 release blocked by busy");
    wr_busy = 1'b0;
    cs_n = 1'b0;
    expect_step(3'd3, 0, 0, 0, 0, "R4 frame before release");
    close_frame(8'hAB, 8);
    expect_step(3'd4, 0, 0, 0, 0, "R4 releasing");
    cs_n = 1'b0;
    for (int k = 0; k < EXIT_CYC; k++) expect_step(3'd4, 0, 0, 0, 0, "R7 release delay");
    expect_step(3'd0, 1, 0, 0, 0, "R7 standby, early frame not gated");
    expect_step(3'd0, 1, 0, 0, 0, "R7 early frame stays ungated");
    cs_n = 1'b1;
    expect_step(3'd0, 1, 0, 0, 0, "R7 early frame closed");
    cs_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R7 fresh frame gated");

    sclk = 1'b1; hold_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R8 hold fall with clock high ignored");
    hold_n = 1'b1;
    expect_step(3'd1, 1, 1, 0, 0, "R8 hold line restored");
    sclk = 1'b0; hold_n = 1'b0;
    expect_step(3'd1, 1, 0, 1, 0, "R8 hold starts with clock low");
    sclk = 1'b1;
    expect_step(3'd1, 1, 0, 1, 0, "R9 clock ignored while held");
    hold_n = 1'b1;
    expect_step(3'd1, 1, 0, 1, 0, "R9 hold rise with clock high keeps hold");
    sclk = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R9 hold ends with clock low");

    quad_phase = 1'b1; hold_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R8 hold ignored in quad phase");
    quad_phase = 1'b0; hold_n = 1'b1;
    expect_step(3'd1, 1, 1, 0, 0, "R8 quad phase over");

    hold_n = 1'b0;
    expect_step(3'd1, 1, 0, 1, 0, "R10 hold before deselect");
    close_frame(8'hB9, 8);
    expect_step(3'd0, 1, 0, 1, 1, "R10 deselect in hold resets interface");
    expect_step(3'd0, 1, 0, 1, 0, "R10 reset pulse one cycle");
    cs_n = 1'b0;
    expect_step(3'd0, 1, 0, 1, 0, "R10 select while held ignored");
    hold_n = 1'b1;
    expect_step(3'd0, 1, 0, 0, 0, "R10 stale frame stays ungated");
    cs_n = 1'b1;
    expect_step(3'd0, 1, 0, 0, 0, "R10 stale frame closed");
    cs_n = 1'b0;
    expect_step(3'd1, 1, 1, 0, 0, "R11 frame after hold release");
    close_frame(8'h03, 40);
    expect_step(3'd0, 1, 0, 0, 0, "R3 read frame closes");

    wait (sb.size() == 0);
    @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule